// File: doc/BRIEF.md
# Cascadable Eight-Way Priority Encoder

The block turns a vector of request lines into the binary number of the most urgent active line. A single stage watches eight requests, where a higher line number means higher urgency, and reports the winner's 3-bit number. It also raises a flag that says whether any of its lines are active. An enable input gates the whole stage. An enable output goes high only when the stage is enabled and sees no request, so it can hand the enable to a stage of lower urgency.

The top level chains stages of this kind into one wider encoder, two stages by default for sixteen requests. The most urgent stage is always enabled, and each stage passes its enable output down to the next. The combined index has two parts. The upper bits give the number of the stage that holds the winner. The lower bits are the OR of every stage's index, which is correct because at most one stage can hold a winner. The whole path is combinational and has no clock or reset.

Top module: `prio_cascade`

## Requirements
- R1: A stage whose enable input is 0 drives index 0, group flag 0 and enable output 0, whatever its requests are.
- R2: A stage whose enable input is 1 and that sees at least one request drives group flag 1, and its index is the number of its highest-numbered active request (bit 7 outranks bit 0).
- R3: In an enabled stage, requests numbered below the winner have no effect on the index or on the flags.
- R4: A stage whose enable input is 1 and that sees no request drives index 0, group flag 0 and enable output 1.
- R5: A stage's enable output is 1 only when its enable input is 1 and all eight of its requests are 0.
- R6: The cascade index `idx_o` (4 bits) is the number of the highest active line of `req_i[15:0]`; bit 3 of `idx_o` is 1 exactly when some line in 15..8 is active.
- R7: Any active line in 15..8 disables the stage that serves lines 7..0, so lines 7..0 never change `idx_o` while a line in 15..8 is active.
- R8: `any_o` is 1 exactly when at least one of the sixteen lines is active, and `none_o` is 1 exactly when all sixteen lines are 0, so `idx_o` reads 0 in that case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 16 | Request lines; line 15 is the most urgent |
| idx_o | output | 4 | Number of the most urgent active line, 0 when none |
| any_o | output | 1 | High when at least one line is active |
| none_o | output | 1 | Enable passed on by the last stage; high when no line is active |

## Verification
The bench drives a single stage through all 512 combinations of its enable and requests. A stage that leaks its index or flags while disabled (R1), lets a lower bit win (R2, R3), or raises the enable output next to an active request (R4, R5) therefore shows up at once. On the cascade, walking-one patterns on each line pick up a swapped or stuck index bit. Patterns with lines active in both halves catch a lower stage that stays enabled: its index would be ORed into the result and give a wrong number (R7). The all-zero pattern and random patterns check the flags and the index together (R6, R8).

// File: rtl/prio_pkg.sv
package prio_pkg;

    // Default geometry of the encoder.
    localparam int unsigned STAGE_REQS   = 8;
    localparam int unsigned STAGE_COUNT  = 2;

    // Bits needed to number a line inside one stage.
    function automatic int unsigned idx_bits(input int unsigned n);
        int unsigned b;
        b = 0;
        while ((1 << b) < n) b++;
        return (b == 0) ? 1 : b;
    endfunction

endpackage

// File: rtl/prio_stage.sv
module prio_stage #(
    parameter int unsigned REQ_W = prio_pkg::STAGE_REQS,
    localparam int unsigned IDX_W = prio_pkg::idx_bits(REQ_W)
) (
    input  logic             en_i,
    input  logic [REQ_W-1:0] req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             gs_o,
    output logic             eout_o
);

    always_comb begin
        // Ascending scan: the last hit, the highest line, wins.
        idx_o = '0;
        for (int k = 0; k < int'(REQ_W); k++) begin
            if (en_i && req_i[k]) idx_o = IDX_W'(k);
        end
        gs_o   = en_i && (req_i != '0);
        eout_o = en_i && (req_i == '0);

        // A gated stage shows nothing on any output.
        assert_gated_quiet_R1: assert (en_i || (idx_o == '0 && !gs_o && !eout_o));
        // The reported line must itself be active.
        assert_winner_active_R2: assert (!gs_o || req_i[idx_o]);
        // Nothing above the winner may be active.
        assert_none_above_R3: assert (!gs_o || ((req_i >> idx_o) == REQ_W'(1)));
        // Passing the enable on implies an idle index.
        assert_idle_index_R4: assert (!eout_o || idx_o == '0);
        // Enable is passed on only from an enabled stage that has no winner.
        assert_pass_exclusive_R5: assert (!eout_o || (en_i && !gs_o));
    end

endmodule

// File: rtl/prio_cascade.sv
module prio_cascade #(
    parameter int unsigned N_STAGES = prio_pkg::STAGE_COUNT,
    parameter int unsigned STAGE_W  = prio_pkg::STAGE_REQS,
    localparam int unsigned TOTAL_W = N_STAGES * STAGE_W,
    localparam int unsigned LOW_W   = prio_pkg::idx_bits(STAGE_W),
    localparam int unsigned SEL_W   = prio_pkg::idx_bits(N_STAGES),
    localparam int unsigned OUT_W   = SEL_W + LOW_W
) (
    input  logic [TOTAL_W-1:0] req_i,
    output logic [OUT_W-1:0]   idx_o,
    output logic               any_o,
    output logic               none_o
);

    // en_chain[s+1] enables stage s; stage s drives en_chain[s].
    logic [N_STAGES:0]              en_chain;
    logic [N_STAGES-1:0][LOW_W-1:0] stage_idx;
    logic [N_STAGES-1:0]            stage_gs;

    assign en_chain[N_STAGES] = 1'b1;

    generate
        for (genvar s = 0; s < int'(N_STAGES); s++) begin : g_stage
            prio_stage #(.REQ_W(STAGE_W)) stage_u (
                .en_i   (en_chain[s+1]),
                .req_i  (req_i[s*STAGE_W +: STAGE_W]),
                .idx_o  (stage_idx[s]),
                .gs_o   (stage_gs[s]),
                .eout_o (en_chain[s])
            );
        end
    endgenerate

    logic [LOW_W-1:0] low_bits;
    logic [SEL_W-1:0] sel_bits;

    always_comb begin
        low_bits = '0;
        sel_bits = '0;
        for (int s = 0; s < int'(N_STAGES); s++) begin
            low_bits = low_bits | stage_idx[s];
            if (stage_gs[s]) sel_bits = sel_bits | SEL_W'(s);
        end
        idx_o  = {sel_bits, low_bits};
        any_o  = |stage_gs;
        none_o = en_chain[0];

        // The enable chain lets at most one stage claim a winner.
        assert_single_group_R7: assert ($onehot0(stage_gs));
        // The two flags of the whole encoder are complementary.
        assert_flags_split_R8: assert (any_o != none_o);
        // An empty encoder reports index zero.
        assert_empty_zero_R6: assert (!none_o || idx_o == '0);
    end

endmodule

// File: tb/prio_cascade_tb_top.sv
module prio_cascade_tb_top;

    localparam time TCK = 4ns;

    logic clk = 1'b0;
    always #(TCK/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Single stage under exhaustive test.
    logic       st_en;
    logic [7:0] st_req;
    logic [2:0] st_idx;
    logic       st_gs, st_eout;

    prio_stage #(.REQ_W(8)) stage_i (
        .en_i(st_en), .req_i(st_req), .idx_o(st_idx), .gs_o(st_gs), .eout_o(st_eout)
    );

    // Sixteen-line cascade.
    logic [15:0] req;
    logic [3:0]  idx;
    logic        any_f, none_f;

    prio_cascade dut_i (.req_i(req), .idx_o(idx), .any_o(any_f), .none_o(none_f));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_stage(input logic en, input logic [7:0] r);
        logic [2:0] n;
        n = 3'd0;
        for (int k = 7; k >= 0; k--) if (r[k]) begin n = 3'(k); break; end
        if (!en) return 5'b0;
        return {n, (r != 8'd0), (r == 8'd0)};
    endfunction

    function automatic logic [5:0] ref_top(input logic [15:0] r);
        logic [3:0] n;
        n = 4'd0;
        for (int k = 15; k >= 0; k--) if (r[k]) begin n = 4'(k); break; end
        return {n, (r != 16'd0), (r == 16'd0)};
    endfunction

    task automatic apply_top(input logic [15:0] v, input string tag);
        @(negedge clk);
        req = v;
        #1;
        check(tag, {idx, any_f, none_f}, ref_top(v));
    endtask

    task automatic t_idle_state;
        @(negedge clk);
        st_en = 1'b0; st_req = 8'd0; req = 16'd0;
        #1;
        check("R1 gated stage idle", {st_idx, st_gs, st_eout}, 5'b0);
        check("R8 cascade idle", {idx, any_f, none_f}, 6'b000001);
    endtask

    task automatic t_stage_exhaustive;
        for (int c = 0; c < 512; c++) begin
            @(negedge clk);
            st_en  = c[8];
            st_req = c[7:0];
            #1;
            if (!st_en)
                check("R1 gated stage", {st_idx, st_gs, st_eout}, 5'b0);
            else if (st_req == 8'd0)
                check("R4 enabled empty stage", {st_idx, st_gs, st_eout}, 5'b00001);
            else
                check("R2 R3 enabled stage winner", {st_idx, st_gs, st_eout}, ref_stage(1'b1, st_req));
            check("R5 enable pass-on", st_eout, st_en && st_req == 8'd0);
        end
    endtask

    task automatic t_walk_one;
        for (int k = 0; k < 16; k++)
            apply_top(16'd1 << k, "R6 walking one");
    endtask

    task automatic t_cross_halves;
        apply_top(16'h0180, "R7 line 8 over line 7");
        apply_top(16'h01FF, "R7 line 8 over all low");
        apply_top(16'h8001, "R7 line 15 over line 0");
        apply_top(16'h0A55, "R7 mixed halves");
        apply_top(16'h00FF, "R6 low half only");
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++)
            apply_top(16'($urandom), "R6 R8 random pattern");
        apply_top(16'hFFFF, "R6 all lines");
        apply_top(16'h0000, "R8 all zero");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(TCK * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_idle_state();
        t_stage_exhaustive();
        t_walk_one();
        t_cross_halves();
        t_random();
        finish_run();
    end

endmodule